// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on separate clocks. The two clocks may be unrelated or the same net. Pointers cross between the domains in Gray code through two-flop synchronisers. The full condition is computed on the write side and the empty condition on the read side, so each side's blocking flag is exact for its own clock.

A static mode input picks the read timing. In standard timing a word is fetched into the output register on the read-clock edge that samples a read enable. In fall-through timing the head word is placed on the output without a request, and the read enable moves to the next word. In that mode the read-side status pin means "output ready" and the write-side status pin means "input ready". A second static input adds one more register stage to both status pins.

Three level flags are provided: almost-empty, almost-full and half-full. The almost flags compare against two thresholds held in write-domain registers. Reset loads a default into both thresholds, and a load strobe can overwrite either one. An output enable gates the read data bus, which stands in for a tri-state driver.

Top module: `dc_fifo_flags`

## Requirements
- R1: Words leave in the order they were accepted. The data path is 18 bits wide. The depth is a parameter, one of 256, 512, 1024, 2048 or 4096.
- R2: In standard timing (fwft_i=0), a read-clock edge that samples rd_en_i=1 while the FIFO is not empty loads the oldest word onto rd_data_o right after that edge. Without such an edge, rd_data_o holds its value.
- R3: In fall-through timing (fwft_i=1), the oldest word appears on rd_data_o with no read request and rd_stat_o=1 means a word is presented. Each sampled rd_en_i=1 advances to the next word, or drops rd_stat_o to 0 when none remains. wr_stat_o=1 means a write would be accepted.
- R4: In standard timing, rd_stat_o=1 means empty and wr_stat_o=1 means full (DEPTH words stored). The edge of the write that fills the last slot sets the internal full state.
- R5: A write sampled while full is dropped. The word count and the later read sequence are unchanged.
- R6: A read sampled while empty is dropped. rd_data_o keeps its value and no later word is lost.
- R7: With dbl_flag_i=0, rd_stat_o falls after the third read-clock edge following the edge that accepted a write into an empty FIFO. With dbl_flag_i=1 it falls one edge later. Full and input-ready get the same extra stage.
- R8: aempty_o=1 while the stored count is at or below the almost-empty threshold.
- R9: afull_o=1 while the free space (DEPTH minus count) is at or below the almost-full threshold.
- R10: hfull_o=1 while the stored count exceeds DEPTH/2.
- R11: A write-clock edge with ofs_ld_i=1 stores ofs_val_i into the almost-empty threshold when ofs_sel_i=0 and into the almost-full threshold when ofs_sel_i=1. Reset restores both thresholds to 7 when DEPTH is 256 and to 63 otherwise.
- R12: With oe_i=0, rd_data_o is all zeros and rd_drive_o=0. With oe_i=1, rd_data_o shows the output register and rd_drive_o=1.
- R13: During and after reset in standard timing the FIFO is empty: rd_stat_o=1, wr_stat_o=0, aempty_o=1, afull_o=0 and hfull_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, for both domains |
| fwft_i | input | 1 | Static mode: 0 standard timing, 1 fall-through timing |
| dbl_flag_i | input | 1 | Static: 1 adds a second register stage to both status pins |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 18 | Write data |
| ofs_ld_i | input | 1 | Threshold load strobe (write clock) |
| ofs_sel_i | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| ofs_val_i | input | AW (8) | Threshold value |
| wr_stat_o | output | 1 | Full (standard) or input ready (fall-through) |
| afull_o | output | 1 | Almost-full flag |
| hfull_o | output | 1 | Half-full flag |
| rd_en_i | input | 1 | Read request |
| oe_i | input | 1 | Output enable |
| rd_data_o | output | 18 | Read data, zero when not enabled |
| rd_drive_o | output | 1 | Bus drive enable, follows oe_i |
| rd_stat_o | output | 1 | Empty (standard) or output ready (fall-through) |
| aempty_o | output | 1 | Almost-empty flag |

## Verification
With both clocks tied to one source, every result has a fixed due cycle. Read data is due right after the accepting read edge, and the bench samples it on the following falling edge. The gate effect of oe_i is combinational and is checked in the same half cycle. Any flag change that depends on the other domain takes three edges to appear, or four with the extra stage, so table steps wait six edges before comparing flags. The stage test alone samples at edges three and four after a single write, to pin down the one-cycle difference between the single and double stage settings.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 18;
  typedef logic [DATA_W-1:0] word_t;
  typedef enum logic {OFS_AE = 1'b0, OFS_AF = 1'b1} ofs_sel_e;

  function automatic int def_ofs(input int depth);
    return (depth == 256) ? 7 : 63;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
// Two-flop Gray synchroniser, binary out
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                  wclk_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  dcf_pkg::word_t        wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output dcf_pkg::word_t        rdata_o
);
  dcf_pkg::word_t mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          dbl_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rbin_s_i,
  input  logic          ofs_ld_i,
  input  logic          ofs_sel_i,
  input  logic [AW-1:0] ofs_val_i,
  output logic          we_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] ae_ofs_o,
  output logic          full_o,
  output logic          stat_o,
  output logic          af_o,
  output logic          hf_o
);
  import dcf_pkg::*;
  localparam logic [AW-1:0] DEF_OFS = AW'(def_ofs(DEPTH));
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, cnt_nx;
  logic [AW-1:0] ae_ofs_q, af_ofs_q;
  logic          full_q, full2_q, af_q, hf_q, full_sel;

  assign we_o    = wr_en_i & ~full_q;
  assign wbin_nx = wbin_q + PW'(we_o);
  assign cnt_nx  = wbin_nx - rbin_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      full_q   <= 1'b0;
      full2_q  <= 1'b0;
      af_q     <= 1'b0;
      hf_q     <= 1'b0;
      ae_ofs_q <= DEF_OFS;
      af_ofs_q <= DEF_OFS;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      full_q  <= (cnt_nx == FULL_CNT);
      full2_q <= full_q;
      af_q    <= (FULL_CNT - cnt_nx) <= {1'b0, af_ofs_q};
      hf_q    <= cnt_nx > HALF_CNT;
      if (ofs_ld_i) begin
        if (ofs_sel_e'(ofs_sel_i) == OFS_AF) af_ofs_q <= ofs_val_i;
        else                                 ae_ofs_q <= ofs_val_i;
      end
    end
  end

  assign full_sel = dbl_i ? full2_q : full_q;
  assign stat_o   = fwft_i ? ~full_sel : full_sel;
  assign wbin_o   = wbin_q;
  assign wgray_o  = wgray_q;
  assign ae_ofs_o = ae_ofs_q;
  assign full_o   = full_q;
  assign af_o     = af_q;
  assign hf_o     = hf_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fwft_i,
  input  logic           dbl_i,
  input  logic           rd_en_i,
  input  logic [PW-1:0]  wbin_s_i,
  input  logic [AW-1:0]  ae_ofs_i,
  input  dcf_pkg::word_t mem_rdata_i,
  output logic [PW-1:0]  rbin_o,
  output logic [PW-1:0]  rgray_o,
  output dcf_pkg::word_t dout_o,
  output logic           empty_o,
  output logic           stat_o,
  output logic           ae_o
);
  logic [PW-1:0]  rbin_q, rgray_q, rbin_nx, cnt_nx;
  logic           empty_q, na2_q, ov_q, ov_nx, pop, ae_q, na, na_sel;
  dcf_pkg::word_t dout_q;

  // fall-through: prefetch whenever the output slot is free or being consumed
  assign pop     = fwft_i ? (~empty_q & (~ov_q | rd_en_i)) : (rd_en_i & ~empty_q);
  assign ov_nx   = fwft_i & (pop | (ov_q & ~rd_en_i));
  assign rbin_nx = rbin_q + PW'(pop);
  assign cnt_nx  = wbin_s_i - rbin_nx + PW'(ov_nx);
  assign na      = fwft_i ? ~ov_q : empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      na2_q   <= 1'b1;
      ov_q    <= 1'b0;
      ae_q    <= 1'b1;
      dout_q  <= '0;
    end else begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      empty_q <= (wbin_s_i == rbin_nx);
      na2_q   <= na;
      ov_q    <= ov_nx;
      ae_q    <= cnt_nx <= {1'b0, ae_ofs_i};
      if (pop) dout_q <= mem_rdata_i;
    end
  end

  assign na_sel  = dbl_i ? na2_q : na;
  assign stat_o  = fwft_i ? ~na_sel : na_sel;
  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
  assign dout_o  = dout_q;
  assign empty_o = empty_q;
  assign ae_o    = ae_q;
endmodule

// File: rtl/dc_fifo_flags.sv
module dc_fifo_flags #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      wclk_i,
  input  logic                      rclk_i,
  input  logic                      rst_ni,
  input  logic                      fwft_i,
  input  logic                      dbl_flag_i,
  input  logic                      wr_en_i,
  input  logic [dcf_pkg::DATA_W-1:0] wr_data_i,
  input  logic                      ofs_ld_i,
  input  logic                      ofs_sel_i,
  input  logic [AW-1:0]             ofs_val_i,
  output logic                      wr_stat_o,
  output logic                      afull_o,
  output logic                      hfull_o,
  input  logic                      rd_en_i,
  input  logic                      oe_i,
  output logic [dcf_pkg::DATA_W-1:0] rd_data_o,
  output logic                      rd_drive_o,
  output logic                      rd_stat_o,
  output logic                      aempty_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0]  wbin, wgray, rbin, rgray, rbin_ws, wbin_rs;
  logic [AW-1:0]  ae_ofs;
  logic           we, full_int, empty_int;
  dcf_pkg::word_t mem_rdata, rd_q;

  dcf_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .dbl_i(dbl_flag_i),
    .wr_en_i(wr_en_i), .rbin_s_i(rbin_ws), .ofs_ld_i(ofs_ld_i),
    .ofs_sel_i(ofs_sel_i), .ofs_val_i(ofs_val_i), .we_o(we), .wbin_o(wbin),
    .wgray_o(wgray), .ae_ofs_o(ae_ofs), .full_o(full_int), .stat_o(wr_stat_o),
    .af_o(afull_o), .hf_o(hfull_o)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .dbl_i(dbl_flag_i),
    .rd_en_i(rd_en_i), .wbin_s_i(wbin_rs), .ae_ofs_i(ae_ofs),
    .mem_rdata_i(mem_rdata), .rbin_o(rbin), .rgray_o(rgray), .dout_o(rd_q),
    .empty_o(empty_int), .stat_o(rd_stat_o), .ae_o(aempty_o)
  );

  dcf_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rbin_ws)
  );

  dcf_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wbin_rs)
  );

  dcf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(wbin[AW-1:0]), .wdata_i(wr_data_i),
    .raddr_i(rbin[AW-1:0]), .rdata_o(mem_rdata)
  );

  assign rd_data_o  = oe_i ? rd_q : '0;
  assign rd_drive_o = oe_i;
endmodule

// File: rtl/dc_fifo_flags_chk.sv
module dc_fifo_flags_chk #(
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          fwft_i,
  input logic          oe_i,
  input logic          rd_en_i,
  input logic          full_int,
  input logic          empty_int,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rbin_ws,
  input logic [17:0]   rd_q,
  input logic [17:0]   rd_data_o,
  input logic          rd_drive_o
);
  // R1: stored count never exceeds depth
  a_r1_count_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin - rbin_ws) <= PW'(DEPTH));

  a_r5_full_holds_wptr: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_int |=> $stable(wbin));

  a_r6_empty_holds_rptr: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_int |=> $stable(rbin));

  a_r2_hold_without_read: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_i && !(rd_en_i && !empty_int)) |=> $stable(rd_q));

  a_r12_bus_quiet: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !oe_i |-> (rd_data_o == '0 && !rd_drive_o));
endmodule

bind dc_fifo_flags dc_fifo_flags_chk #(.DEPTH(DEPTH), .PW(AW + 1)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i),
  .oe_i(oe_i), .rd_en_i(rd_en_i), .full_int(full_int), .empty_int(empty_int),
  .wbin(wbin), .rbin(rbin), .rbin_ws(rbin_ws), .rd_q(rd_q),
  .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
);

// File: tb/dc_fifo_flags_bench.sv
`timescale 1ns/1ps
module dc_fifo_flags_bench;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  // wr, rd, empty, full, half, aempty, afull
  localparam int TBL [10][7] = '{
    '{1,   0,   0, 0, 0, 1, 0},
    '{7,   0,   0, 0, 0, 0, 0},
    '{121, 0,   0, 0, 1, 0, 0},
    '{120, 0,   0, 0, 1, 0, 1},
    '{7,   0,   0, 1, 1, 0, 1},
    '{3,   0,   0, 1, 1, 0, 1},
    '{0,   1,   0, 0, 1, 0, 1},
    '{0,   250, 0, 0, 0, 1, 0},
    '{0,   5,   1, 0, 0, 1, 0},
    '{0,   2,   1, 0, 0, 1, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwft = 1'b0, dbl = 1'b0, wr_en = 1'b0, ofs_ld = 1'b0, ofs_sel = 1'b0;
  logic rd_en = 1'b0, oe = 1'b1;
  logic [17:0] wr_data = '0;
  logic [AW-1:0] ofs_val = '0;
  logic wr_stat_o, afull_o, hfull_o, rd_drive_o, rd_stat_o, aempty_o;
  logic [17:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [17:0] seq = 18'd1;
  logic [17:0] q[$];

  always #10 clk = ~clk;

  dc_fifo_flags #(.DEPTH(DEPTH), .AW(AW)) u_dc_fifo_flags (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .fwft_i(fwft),
    .dbl_flag_i(dbl), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ofs_ld_i(ofs_ld), .ofs_sel_i(ofs_sel), .ofs_val_i(ofs_val),
    .wr_stat_o(wr_stat_o), .afull_o(afull_o), .hfull_o(hfull_o),
    .rd_en_i(rd_en), .oe_i(oe), .rd_data_o(rd_data_o),
    .rd_drive_o(rd_drive_o), .rd_stat_o(rd_stat_o), .aempty_o(aempty_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m_fwft, input logic m_dbl);
    @(negedge clk);
    rst_n = 1'b0; fwft = m_fwft; dbl = m_dbl;
    wr_en = 1'b0; rd_en = 1'b0; ofs_ld = 1'b0;
    q.delete();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin wr_en = 1'b1; wr_data = seq; end
      @(posedge clk);
      #1 wr_en = 1'b0;
      if (q.size() < DEPTH) q.push_back(seq);
      seq++;
    end
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      logic [17:0] prev;
      prev = rd_data_o;
      @(negedge clk) rd_en = 1'b1;
      @(posedge clk);
      #1 rd_en = 1'b0;
      @(negedge clk);
      if (q.size() > 0) chk("R2 R1 read data order", rd_data_o, q.pop_front());
      else chk("R6 read while empty keeps data", rd_data_o, prev);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_ofs(input logic sel, input int val);
    @(negedge clk) begin ofs_ld = 1'b1; ofs_sel = sel; ofs_val = AW'(val); end
    @(posedge clk);
    #1 ofs_ld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R13 reset state
    do_reset(1'b0, 1'b0);
    chk("R13 empty after reset", rd_stat_o, 1);
    chk("R13 full after reset", wr_stat_o, 0);
    chk("R13 aempty after reset", aempty_o, 1);
    chk("R13 afull after reset", afull_o, 0);
    chk("R13 hfull after reset", hfull_o, 0);

    // table walk: R4 R5 R6 R8 R9 R10 with default offsets
    for (int s = 0; s < 10; s++) begin
      write_n(TBL[s][0]);
      read_n(TBL[s][1]);
      settle();
      chk("R4 empty flag", rd_stat_o, TBL[s][2]);
      chk("R4 R5 full flag", wr_stat_o, TBL[s][3]);
      chk("R10 half flag", hfull_o, TBL[s][4]);
      chk("R8 aempty flag", aempty_o, TBL[s][5]);
      chk("R9 afull flag", afull_o, TBL[s][6]);
    end

    // R11 threshold load and restore
    load_ofs(1'b0, 20);
    write_n(15);
    settle();
    chk("R11 R8 aempty at 15 with threshold 20", aempty_o, 1);
    write_n(6);
    settle();
    chk("R11 R8 aempty at 21 with threshold 20", aempty_o, 0);
    load_ofs(1'b1, 100);
    settle();
    chk("R11 R9 afull free 235 threshold 100", afull_o, 0);
    write_n(135);
    settle();
    chk("R11 R9 afull free 100 threshold 100", afull_o, 1);
    do_reset(1'b0, 1'b0);
    write_n(10);
    settle();
    chk("R11 aempty default restored", aempty_o, 0);
    chk("R11 afull default restored", afull_o, 0);

    // R7 single stage
    do_reset(1'b0, 1'b0);
    write_n(1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 single still empty at edge 2", rd_stat_o, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 single not empty at edge 3", rd_stat_o, 0);

    // R7 double stage
    do_reset(1'b0, 1'b1);
    write_n(1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R7 double still empty at edge 2", rd_stat_o, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 double still empty at edge 3", rd_stat_o, 1);
    @(posedge clk); @(negedge clk);
    chk("R7 double not empty at edge 4", rd_stat_o, 0);

    // R12 output enable
    @(negedge clk) oe = 1'b0;
    @(negedge clk) rd_en = 1'b1;
    @(posedge clk);
    #1 rd_en = 1'b0;
    @(negedge clk);
    chk("R12 bus zero when disabled", rd_data_o, 0);
    chk("R12 drive low when disabled", rd_drive_o, 0);
    oe = 1'b1;
    #1;
    chk("R12 drive high when enabled", rd_drive_o, 1);
    chk("R12 R2 data shown when enabled", rd_data_o, q.pop_front());

    // R3 fall-through timing
    do_reset(1'b1, 1'b0);
    chk("R3 not ready after reset", rd_stat_o, 0);
    chk("R3 input ready after reset", wr_stat_o, 1);
    write_n(3);
    settle();
    chk("R3 ready without read", rd_stat_o, 1);
    chk("R3 head word presented", rd_data_o, q[0]);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) rd_en = 1'b1;
      @(posedge clk);
      #1 rd_en = 1'b0;
      @(negedge clk);
      void'(q.pop_front());
      if (q.size() > 0) begin
        chk("R3 advance to next word", rd_data_o, q[0]);
        chk("R3 ready while words remain", rd_stat_o, 1);
      end else begin
        chk("R3 ready drops after last word", rd_stat_o, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule